// File: doc/BRIEF.md
# Fifth-order sinc decimation filter

This block is the first decimation stage behind a multibit sigma-delta modulator. It takes a 5-bit two's-complement sample on each strobe at the modulator rate. It runs the samples through a fifth-order cascaded integrator-comb filter, which gives a sinc^5 response, and emits one wider sample for every group of strobes. A single select input picks the group size. In the 48 kHz setting the ratio is 16, fed at 128x fs. In the 96 kHz setting the ratio is 8, fed at 64x fs. Either way the output runs at 8x the final sample rate: 384 kHz or 768 kHz. Half-band stages downstream take it from there.

The integrators and combs carry full precision in 25-bit wrap-around arithmetic. This width covers the worst-case growth at ratio 16, so intermediate overflow cancels exactly. The ÷16 result is shifted right by 5 bits, so both ratios deliver the same 20-bit full scale. A change of the select input wipes all filter state and restarts the group count, so a result never mixes samples taken under two ratios.

Top module: `sinc5_decimator`

## Requirements
- R1: While reset is held and in the first cycle after it, `dec_vld_o` is 0 and `dec_o` is 0.
- R2: With `rate_sel_i` = 0 (ratio 16), `dec_vld_o` is high for exactly one cycle, two clock edges after every 16th accepted strobe. Strobes are counted from reset or from the last rate change.
- R3: With `rate_sel_i` = 1 (ratio 8), `dec_vld_o` is high for one cycle, two edges after every 8th accepted strobe. Consecutive pulses are at least 8 cycles apart.
- R4: At ratio 16, let n be the index of the strobe that completes a group, and let h be the coefficients of ((1 - z^-16)/(1 - z^-1))^5. The output is floor(y/32), where y = sum over j of h[j]*x[n-4-j] and samples before the last reset or rate change count as 0.
- R5: At ratio 8, the output is y itself, with h built from ratio 8.
- R6: A steady input of -16 gives -524288 at both ratios. A steady input of 15 gives 491520 at both ratios.
- R7: A change of `rate_sel_i` clears all integrator and comb state and the group count. A strobe in the change cycle is discarded. A result still in flight from the previous cycle is dropped. `dec_vld_o` stays low for the two cycles after the change.
- R8: Cycles without a strobe advance neither the filter nor the group count, whatever the input data.
- R9: The 25-bit datapath wraps silently, and long runs of extreme inputs (-16 and 15) still give exact results under R4 and R5.
- R10: `dec_o` keeps its last value in every cycle where `dec_vld_o` is low, across rate changes too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rate_sel_i | input | 1 | 0: decimate by 16; 1: decimate by 8 |
| smp_vld_i | input | 1 | Input sample strobe |
| smp_i | input | 5 | Modulator sample, two's complement |
| dec_vld_o | output | 1 | One-cycle result strobe |
| dec_o | output | 20 | Decimated result, two's complement |

## Verification
A result is due in the cycle after the second rising edge that follows the strobe completing a group. That strobe is sampled at edge one, the group tick is registered there, and the output register loads at edge two. The bench drives and samples on falling edges. Each expectation passes through a two-slot queue, so valid and data are compared in exactly the due cycle, and every other cycle is checked for a low valid and an unchanged word. When the rate changes, the bench empties the queue slot whose result the design drops, and it restarts its own group count.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;

    // Input and filter shape
    localparam int IN_W   = 5;
    localparam int ORDER  = 5;
    localparam int R_MAX  = 16;
    localparam int R_MIN  = 8;

    // Derived widths
    localparam int GROW_MAX   = ORDER * $clog2(R_MAX);
    localparam int ACC_W      = IN_W + GROW_MAX;
    localparam int OUT_W      = IN_W + ORDER * $clog2(R_MIN);
    localparam int NORM_SHIFT = ACC_W - OUT_W;
    localparam int CNT_W      = $clog2(R_MAX);

    typedef logic signed [IN_W-1:0]  smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [OUT_W-1:0] out_t;
    typedef logic [CNT_W-1:0]        phase_t;

    typedef enum logic {
        RATE_DIV16 = 1'b0,
        RATE_DIV8  = 1'b1
    } rate_e;

    typedef struct packed {
        logic strobe;
        acc_t value;
    } acc_beat_t;

    // Last phase index of a decimation group
    function automatic phase_t last_phase(input rate_e r);
        return (r == RATE_DIV16) ? phase_t'(R_MAX - 1) : phase_t'(R_MIN - 1);
    endfunction

    // Sign-extend a modulator sample to accumulator width
    function automatic acc_t widen(input smp_t x);
        return {{(ACC_W - IN_W){x[IN_W-1]}}, x};
    endfunction

    // Bring both ratios to the same output full scale
    function automatic out_t normalize(input acc_t a, input rate_e r);
        acc_t s;
        s = (r == RATE_DIV16) ? (a >>> NORM_SHIFT) : a;
        return s[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/sinc5_integ_chain.sv
module sinc5_integ_chain
    import sinc5_pkg::*;
#(
    parameter int STAGES = ORDER
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      clr_i,
    input  acc_beat_t in_i,
    output acc_t      out_o
);

    acc_t taps [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        acc_t feed;
        acc_t stage_q;

        if (k == 0) begin : g_first
            assign feed = in_i.value;
        end else begin : g_next
            assign feed = taps[k-1];
        end

        // Each stage adds the previous stage's registered value: one pipeline
        // step per stage, modular arithmetic.
        always_ff @(posedge clk_i) begin
            if (rst_i || clr_i) begin
                stage_q <= '0;
            end else if (in_i.strobe) begin
                stage_q <= stage_q + feed;
            end
        end

        assign taps[k] = stage_q;
    end

    assign out_o = taps[STAGES-1];

endmodule

// File: rtl/sinc5_phase_ctr.sv
module sinc5_phase_ctr
    import sinc5_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  clr_i,
    input  logic  strobe_i,
    input  rate_e rate_i,
    output logic  tick_o
);

    phase_t cnt_q;
    phase_t last;
    logic   wrap;

    assign last = last_phase(rate_i);
    assign wrap = (cnt_q == last);

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= strobe_i && wrap;
            if (strobe_i) begin
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sinc5_comb_chain.sv
module sinc5_comb_chain
    import sinc5_pkg::*;
#(
    parameter int STAGES = ORDER
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic tick_i,
    input  acc_t din_i,
    output acc_t dout_o
);

    acc_t dly [STAGES];
    acc_t diff [STAGES+1];

    always_comb begin
        diff[0] = din_i;
        for (int k = 0; k < STAGES; k++) begin
            diff[k+1] = diff[k] - dly[k];
        end
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        acc_t dly_q;

        always_ff @(posedge clk_i) begin
            if (rst_i || clr_i) begin
                dly_q <= '0;
            end else if (tick_i) begin
                dly_q <= diff[k];
            end
        end

        assign dly[k] = dly_q;
    end

    assign dout_o = diff[STAGES];

endmodule

// File: rtl/sinc5_decimator.sv
module sinc5_decimator
    import sinc5_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rate_sel_i,
    input  logic             smp_vld_i,
    input  logic [IN_W-1:0]  smp_i,
    output logic             dec_vld_o,
    output logic [OUT_W-1:0] dec_o
);

    rate_e     rate_q;
    rate_e     rate_in;
    logic      clr;
    acc_beat_t beat;
    acc_t      integ_out;
    acc_t      comb_out;
    logic      tick;

    assign rate_in = rate_e'(rate_sel_i);
    assign clr     = (rate_in != rate_q);

    // Rate register follows the input even in reset, so a select held
    // through reset does not count as a change afterwards.
    always_ff @(posedge clk_i) begin
        rate_q <= rate_in;
    end

    assign beat.strobe = smp_vld_i && !clr;
    assign beat.value  = widen(smp_t'(smp_i));

    sinc5_integ_chain #(.STAGES(ORDER)) u_integ (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (clr),
        .in_i  (beat),
        .out_o (integ_out)
    );

    sinc5_phase_ctr u_phase (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clr_i    (clr),
        .strobe_i (beat.strobe),
        .rate_i   (rate_q),
        .tick_o   (tick)
    );

    sinc5_comb_chain #(.STAGES(ORDER)) u_comb (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (clr),
        .tick_i (tick),
        .din_i  (integ_out),
        .dout_o (comb_out)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dec_vld_o <= 1'b0;
            dec_o     <= '0;
        end else if (clr) begin
            dec_vld_o <= 1'b0;
        end else begin
            dec_vld_o <= tick;
            if (tick) begin
                dec_o <= normalize(comb_out, rate_q);
            end
        end
    end

endmodule

// File: rtl/sinc5_decimator_chk.sv
module sinc5_decimator_chk
    import sinc5_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             rate_sel_i,
    input logic             dec_vld_o,
    input logic [OUT_W-1:0] dec_o
);

    logic [7:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q <= 8'hFF;
        end else if (dec_vld_o) begin
            gap_q <= 8'd0;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    // R1: nothing valid right after reset
    a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> !dec_vld_o);

    // R2: the result strobe lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        dec_vld_o |=> !dec_vld_o);

    // R3: pulses are never closer than the smaller ratio
    a_r3_min_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
        dec_vld_o |-> (gap_q >= 8'(R_MIN - 1)));

    // R7: a rate change silences the output for two cycles
    a_r7_quiet_after_switch: assert property (@(posedge clk_i) disable iff (rst_i)
        (rate_sel_i != $past(rate_sel_i)) |=> !dec_vld_o ##1 !dec_vld_o);

    // R10: the word holds between strobes
    a_r10_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !dec_vld_o |-> $stable(dec_o));

endmodule

bind sinc5_decimator sinc5_decimator_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rate_sel_i (rate_sel_i),
    .dec_vld_o  (dec_vld_o),
    .dec_o      (dec_o)
);

// File: tb/sinc5_decimator_bench.sv
module sinc5_decimator_bench;

    logic        clk = 1'b0;
    logic        rst_i;
    logic        rate_sel_i;
    logic        smp_vld_i;
    logic [4:0]  smp_i;
    logic        dec_vld_o;
    logic [19:0] dec_o;

    always #10 clk = ~clk;

    sinc5_decimator u_sinc5_decimator (
        .clk_i      (clk),
        .rst_i      (rst_i),
        .rate_sel_i (rate_sel_i),
        .smp_vld_i  (smp_vld_i),
        .smp_i      (smp_i),
        .dec_vld_o  (dec_vld_o),
        .dec_o      (dec_o)
    );

    int    n_checks = 0;
    int    n_err    = 0;
    int    hist[$];
    int    h [0:79];
    int    cur_r    = 16;
    bit    cur_mode = 1'b0;
    bit    exp_v [2];
    int    exp_d [2];
    int    last_out = 0;
    string tag      = "R1";
    bit    done     = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Coefficients of the r-long boxcar convolved with itself five times
    task automatic build_h(input int r);
        int tmp [0:79];
        for (int i = 0; i < 80; i++) h[i] = (i < r) ? 1 : 0;
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 80; i++) tmp[i] = 0;
            for (int i = 0; i < 80; i++) begin
                if (h[i] != 0) begin
                    for (int j = 0; j < r; j++) begin
                        if (i + j < 80) tmp[i+j] += h[i];
                    end
                end
            end
            for (int i = 0; i < 80; i++) h[i] = tmp[i];
        end
    endtask

    function automatic int model_out();
        int n;
        int y;
        n = hist.size() - 1;
        y = 0;
        for (int j = 0; j <= 5 * cur_r - 5; j++) begin
            if (n - 4 - j >= 0) y += h[j] * hist[n-4-j];
        end
        if (cur_r == 16) y = y >>> 5;
        return y;
    endfunction

    function automatic int rnd_smp();
        return int'($urandom_range(31)) - 16;
    endfunction

    function automatic int rnd_ext();
        return ($urandom_range(1) == 0) ? -16 : 15;
    endfunction

    // One cycle: check what is due now, update the model, drive the next input
    task automatic cyc(input bit m, input bit v, input int d);
        int act;
        @(negedge clk);
        act = int'($signed(dec_o));
        check(dec_vld_o === exp_v[1], {tag, " valid timing"}, int'(dec_vld_o), int'(exp_v[1]));
        if (exp_v[1]) begin
            check(act == exp_d[1], {tag, " data"}, act, exp_d[1]);
            last_out = exp_d[1];
        end else begin
            check(act == last_out, "R10 hold", act, last_out);
        end
        exp_v[1] = exp_v[0];
        exp_d[1] = exp_d[0];
        exp_v[0] = 1'b0;
        if (m != cur_mode) begin
            cur_mode = m;
            cur_r    = m ? 8 : 16;
            build_h(cur_r);
            hist.delete();
            exp_v[1] = 1'b0;
        end else if (v) begin
            hist.push_back(d);
            if (hist.size() % cur_r == 0) begin
                exp_v[0] = 1'b1;
                exp_d[0] = model_out();
            end
        end
        rate_sel_i = m;
        smp_vld_i  = v;
        smp_i      = d[4:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(cur_mode, 1'b0, rnd_smp());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog R2: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0801));
        exp_v[0] = 1'b0; exp_v[1] = 1'b0;
        exp_d[0] = 0;    exp_d[1] = 0;
        build_h(16);
        rst_i = 1'b1; rate_sel_i = 1'b0; smp_vld_i = 1'b0; smp_i = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: outputs in reset
        check(dec_vld_o === 1'b0, "R1 valid in reset", int'(dec_vld_o), 0);
        check(dec_o === 20'd0, "R1 data in reset", int'(dec_o), 0);
        rst_i = 1'b0;
        tag = "R1";
        idle(2);

        // R2: ratio 16, strobe every cycle
        tag = "R2";
        for (int i = 0; i < 64; i++) cyc(1'b0, 1'b1, rnd_smp());
        idle(3);

        // R4: ratio 16, random data and gaps
        tag = "R4";
        for (int i = 0; i < 600; i++) cyc(1'b0, $urandom_range(99) < 60, rnd_smp());

        // R8: long idle stretches with data toggling on the input
        tag = "R8";
        for (int i = 0; i < 120; i++) begin
            if ($urandom_range(2) == 0) idle(int'($urandom_range(20)) + 1);
            else cyc(1'b0, 1'b1, rnd_smp());
        end

        // R7: switch mid-group with a strobe in the change cycle
        tag = "R7";
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, rnd_smp());
        cyc(1'b1, 1'b1, 15);
        for (int i = 0; i < 24; i++) cyc(1'b1, 1'b1, rnd_smp());

        // R3: ratio 8, strobe every cycle
        tag = "R3";
        for (int i = 0; i < 64; i++) cyc(1'b1, 1'b1, rnd_smp());
        idle(3);

        // R5: ratio 8, random data and gaps
        tag = "R5";
        for (int i = 0; i < 600; i++) cyc(1'b1, $urandom_range(99) < 60, rnd_smp());

        // R7: change right after a group completes drops that result
        tag = "R7";
        while (hist.size() % 8 != 7) cyc(1'b1, 1'b1, rnd_smp());
        cyc(1'b1, 1'b1, rnd_smp());
        cyc(1'b0, 1'b1, rnd_smp());
        cyc(1'b1, 1'b0, 0);
        cyc(1'b0, 1'b0, 0);
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1, rnd_smp());
        idle(3);

        // R6: full scale matches across ratios
        tag = "R6";
        for (int i = 0; i < 100; i++) cyc(1'b0, 1'b1, -16);
        idle(3);
        check(last_out == -524288, "R6 div16 negative full scale", last_out, -524288);
        for (int i = 0; i < 100; i++) cyc(1'b0, 1'b1, 15);
        idle(3);
        check(last_out == 491520, "R6 div16 positive full scale", last_out, 491520);
        cyc(1'b1, 1'b0, 0);
        for (int i = 0; i < 100; i++) cyc(1'b1, 1'b1, -16);
        idle(3);
        check(last_out == -524288, "R6 div8 negative full scale", last_out, -524288);
        for (int i = 0; i < 100; i++) cyc(1'b1, 1'b1, 15);
        idle(3);
        check(last_out == 491520, "R6 div8 positive full scale", last_out, 491520);

        // R9: long extreme runs exercise wrap-around
        tag = "R9";
        for (int i = 0; i < 1000; i++) cyc(1'b1, 1'b1, rnd_ext());
        for (int i = 0; i < 2000; i++) cyc(1'b0, 1'b1, rnd_ext());
        idle(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule